// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns the start of a memory column access into a stream of column addresses, one per clock, for the beats of a read or write burst. A controller pulses a start input with the first column, a burst-length code, an ordering bit, the direction of the access and a flag that limits writes to one beat. The generator then presents each beat's column on a registered output, together with a beat-valid strobe and a flag on the final beat.

Two orderings are available inside the naturally aligned block of burst length BL. In wrapping order the low log2(BL) bits count up modulo BL and the upper bits stay fixed. In interleaved order each column is the start column XOR the beat index. A page-length code runs all 256 columns of the row in wrapping order, whatever the ordering bit says. A stop input ends any burst early. A new start may arrive on any cycle and replaces the burst in progress.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released with no start, beat_valid_o and last_o are 0.
- R2: A start_i sampled at a clock edge makes beat_valid_o 1 after that edge, with col_o equal to the sampled start_col_i (beat 0).
- R3: Length code (len_code_i) 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats on consecutive cycles; last_o is 1 only on the final beat, and beat_valid_o is 0 on the cycle after it unless a new start was sampled.
- R4: With type_i = 0 (wrapping order), beat k shows the start column with its low log2(BL) bits replaced by (start + k) mod BL, and the upper bits unchanged.
- R5: With type_i = 1 (interleaved order) and length codes 0 to 3, beat k shows start_col_i XOR k.
- R6: Length code 7 is a page burst of 256 beats in wrapping order mod 256, even when type_i = 1; last_o is 1 only on the 256th beat.
- R7: Reserved length codes 4, 5 and 6 give a one-beat burst.
- R8: When single_wr_i = 1 and is_write_i = 1, the burst is one beat long. When is_write_i = 0 the programmed length applies, whatever single_wr_i is.
- R9: A stop_i sampled at an edge while a burst is active, with no start, makes beat_valid_o 0 after that edge. A page burst or any burst stopped before its final beat never shows last_o.
- R10: A start_i sampled during a burst restarts the generator with the new column and settings. A start takes priority over a stop sampled at the same edge.
- R11: last_o is never 1 while beat_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst at start_col_i |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code: 0..3 give 1/2/4/8 beats, 7 gives a page, others give 1 |
| type_i | input | 1 | 0 wrapping order, 1 interleaved order |
| single_wr_i | input | 1 | Restrict writes to one beat |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| stop_i | input | 1 | End the active burst |
| beat_valid_o | output | 1 | A burst beat is presented |
| col_o | output | 8 | Column address of the current beat |
| last_o | output | 1 | The current beat is the final one |

## Verification
The bench goes after start columns that sit in the middle or at the top of their aligned block. There, a generator that carried into the upper bits, or that used addition in interleaved mode, would emit columns outside the block. Page bursts that start near 255 expose a generator that fails to wrap to 0 or that stops at the block edge, and a page burst with the ordering bit set catches one that XORs instead of counting. It also times stop and restart exactly. A design that honoured stop one beat late, let a stopped burst raise last_o, or let stop beat a simultaneous start would show an extra beat or a missing first column. Single-beat writes are checked next to reads under the same flag, to catch a design that shortened both.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int LEN_W = 3;
  localparam logic [LEN_W-1:0] LEN_CODE_PAGE = 3'd7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/bcg_len_dec.sv
module bcg_len_dec
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             type_i,
  input  logic             single_wr_i,
  input  logic             is_write_i,
  output logic [COL_W-1:0] mask_o,
  output order_e           ord_o
);
  // mask = BL-1; index runs 0..mask
  always_comb begin
    case (len_code_i)
      3'd0:          mask_o = '0;
      3'd1:          mask_o = COL_W'(1);
      3'd2:          mask_o = COL_W'(3);
      3'd3:          mask_o = COL_W'(7);
      LEN_CODE_PAGE: mask_o = '1;
      default:       mask_o = '0;
    endcase
    if (single_wr_i && is_write_i) mask_o = '0;
  end

  // page bursts always wrap
  assign ord_o = (type_i && (len_code_i != LEN_CODE_PAGE)) ? ORD_ILV : ORD_SEQ;
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + idx_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])             col_o[b] = base_i[b];
      else if (ord_i == ORD_ILV)  col_o[b] = base_i[b] ^ idx_i[b];
      else                        col_o[b] = sum[b];
    end
  end
endmodule

// File: rtl/bcg_beat_seq.sv
module bcg_beat_seq
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           ord_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output order_e           ord_o,
  output logic             final_o
);
  logic             active_q;
  logic [COL_W-1:0] idx_q, base_q, mask_q;
  order_e           ord_q;

  assign final_o = active_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      ord_q    <= ORD_SEQ;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= start_col_i;
      mask_q   <= mask_i;
      ord_q    <= ord_i;
    end else if (active_q) begin
      if (stop_i || final_o) active_q <= 1'b0;
      else                   idx_q    <= idx_q + COL_W'(1);
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign mask_o   = mask_q;
  assign ord_o    = ord_q;

  // R9: stop ends the burst at the next edge
  a_r9_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stop_i && !start_i) |=> !active_q);
  // R3: index never passes the burst mask
  a_r3_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> ((idx_q & ~mask_q) == '0));
  // R3: beats run back to back until the final one
  a_r3_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !final_o && !stop_i) |=> active_q);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [LEN_W-1:0] len_code_i,
  input  logic             type_i,
  input  logic             single_wr_i,
  input  logic             is_write_i,
  input  logic             stop_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, base, idx, mask;
  order_e           dec_ord, ord;
  logic             active, fin;

  bcg_len_dec #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .type_i     (type_i),
    .single_wr_i(single_wr_i),
    .is_write_i (is_write_i),
    .mask_o     (dec_mask),
    .ord_o      (dec_ord)
  );

  bcg_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .start_col_i(start_col_i),
    .mask_i     (dec_mask),
    .ord_i      (dec_ord),
    .active_o   (active),
    .base_o     (base),
    .idx_o      (idx),
    .mask_o     (mask),
    .ord_o      (ord),
    .final_o    (fin)
  );

  bcg_col_map #(.COL_W(COL_W)) u_map (
    .base_i(base),
    .idx_i (idx),
    .mask_i(mask),
    .ord_i (ord),
    .col_o (col_o)
  );

  assign beat_valid_o = active;
  assign last_o       = fin;

  // R11
  a_r11_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);
  // R2, R10: first beat carries the sampled column
  a_r2_first_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (beat_valid_o && col_o == $past(start_col_i)));
  // R3: nothing follows the final beat without a new start
  a_r3_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !beat_valid_o);
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       type_i = 1'b0;
  logic       single_wr_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       beat_valid_o;
  logic [7:0] col_o;
  logic       last_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_col_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .type_i(type_i), .single_wr_i(single_wr_i),
    .is_write_i(is_write_i), .stop_i(stop_i), .beat_valid_o(beat_valid_o),
    .col_o(col_o), .last_o(last_o)
  );

  function automatic int exp_len(input logic [2:0] code, input bit sw, input bit wr);
    if (sw && wr) return 1;
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] sc, input int k, input int bl,
                                         input bit ty, input logic [2:0] code);
    int blk, off;
    if (ty && code != 3'd7) return sc ^ 8'(k);
    blk = (int'(sc) / bl) * bl;
    off = (int'(sc) % bl + k) % bl;
    return 8'(blk + off);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_beat(input string tag, input logic [7:0] ec, input bit el);
    chk(beat_valid_o === 1'b1 && col_o === ec && last_o === el, tag, "beat {v,col,last}",
        {23'd0, beat_valid_o, col_o}, {23'd0, 1'b1, ec});
    if (last_o !== el) chk(1'b0, tag, "last", 32'(last_o), 32'(el));
  endtask

  task automatic chk_idle(input string tag);
    chk(beat_valid_o === 1'b0 && last_o === 1'b0, tag, "idle {v,last}",
        {30'd0, beat_valid_o, last_o}, 32'd0);
  endtask

  task automatic issue(input logic [7:0] sc, input logic [2:0] code, input bit ty,
                       input bit sw, input bit wr, input bit stp);
    start_i = 1'b1; start_col_i = sc; len_code_i = code; type_i = ty;
    single_wr_i = sw; is_write_i = wr; stop_i = stp;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  // stop_at < 0: run to completion
  task automatic burst(input logic [7:0] sc, input logic [2:0] code, input bit ty,
                       input bit sw, input bit wr, input int stop_at, input string tag);
    int n;
    n = exp_len(code, sw, wr);
    issue(sc, code, ty, sw, wr, 1'b0);
    for (int j = 0; j < n; j++) begin
      chk_beat(tag, exp_col(sc, j, n, ty, code), j == n - 1);
      if (j == stop_at && j < n - 1) begin
        stop_i = 1'b1;
        @(negedge clk_i);
        stop_i = 1'b0;
        chk_idle({tag, " R9 stop"});
        return;
      end
      @(negedge clk_i);
    end
    chk_idle({tag, " end"});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_idle("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after reset");

    for (int c = 0; c < 4; c++) begin
      burst(8'h5D, 3'(c), 1'b0, 1'b0, 1'b0, -1, "R3 R4 seq");
      burst(8'h5D, 3'(c), 1'b1, 1'b0, 1'b0, -1, "R3 R5 ilv");
      burst(8'hFE, 3'(c), 1'b0, 1'b0, 1'b1, -1, "R4 seq top");
    end
    burst(8'hF3, 3'd7, 1'b0, 1'b0, 1'b0, -1, "R6 page");
    burst(8'h81, 3'd7, 1'b1, 1'b0, 1'b0, -1, "R6 page type1");
    for (int c = 4; c < 7; c++) burst(8'h37, 3'(c), 1'b1, 1'b0, 1'b0, -1, "R7 reserved");
    burst(8'h2A, 3'd3, 1'b0, 1'b1, 1'b1, -1, "R8 single write");
    burst(8'h2A, 3'd3, 1'b0, 1'b1, 1'b0, -1, "R8 read burst");
    burst(8'h2A, 3'd3, 1'b1, 1'b0, 1'b1, -1, "R8 write burst");
    burst(8'h2A, 3'd7, 1'b0, 1'b1, 1'b1, -1, "R8 single write page");
    burst(8'h44, 3'd3, 1'b0, 1'b0, 1'b0, 2, "R9 stop mid");
    burst(8'h44, 3'd2, 1'b1, 1'b0, 1'b0, 0, "R9 stop first");
    burst(8'hFA, 3'd7, 1'b0, 1'b0, 1'b0, 100, "R9 page stop");

    // R10 restart mid burst, with stop at the same edge
    issue(8'h10, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_beat("R10 old b0", 8'h10, 1'b0);
    @(negedge clk_i);
    chk_beat("R10 old b1", 8'h11, 1'b0);
    issue(8'h27, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int j = 0; j < 4; j++) begin
      chk_beat("R10 restart", 8'h27 ^ 8'(j), j == 3);
      @(negedge clk_i);
    end
    chk_idle("R10 end");
    // R10 back-to-back starts each cycle
    for (int j = 0; j < 4; j++) begin
      issue(8'(8'h60 + 8'(j * 9)), 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      chk_beat("R10 b2b", 8'(8'h60 + 8'(j * 9)), 1'b0);
    end
    @(negedge clk_i);
    chk_beat("R10 b2b cont", 8'h7C, 1'b0);
    stop_i = 1'b1; @(negedge clk_i); stop_i = 1'b0;
    chk_idle("R9 after b2b");

    void'($urandom(32'd1234));
    for (int i = 0; i < 200; i++) begin
      logic [7:0] sc;
      logic [2:0] code;
      bit ty, sw, wr;
      int sa;
      sc = 8'($urandom); code = 3'($urandom); ty = 1'($urandom);
      sw = 1'($urandom); wr = 1'($urandom);
      sa = ($urandom % 4 == 0) ? int'($urandom % 12) : -1;
      burst(sc, code, ty, sw, wr, sa, "R3 R4 R5 R6 R7 R8 R9 random");
      if ($urandom % 3 == 0) begin
        @(negedge clk_i);
        chk_idle("R1 gap idle");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule